// File: doc/BRIEF.md
# Per-Context CRC Accumulator

This block computes a cyclic redundancy check beside the main execution datapath. Each operation presents a 32-bit data word, a context number and a type bit. The block folds the word into that context's running remainder and writes the new remainder back to the context's register. One cycle later it returns the same value as a result. The type bit picks CRC-32 or CRC-16 for each operation, so different checks can be mixed in one stream of work.

Software sets the starting value of a context by loading its remainder register directly. It can observe any context's remainder through a combinational read port. Operations may be issued on every cycle. Results come back in order, one cycle after each strobe.

Top module: `crc_accum`

## Requirements
- R1: With `op_type` = 1 (CRC-32), the new remainder is the old 32-bit remainder advanced over all 32 data bits, most significant bit first, with generator 0x04C11DB7. From a zero remainder, data 0x00000001 gives 0x04C11DB7.
- R2: With `op_type` = 0 (CRC-16), only bits [15:0] of the old remainder are used. They are advanced over all 32 data bits, most significant bit first, with generator 0x1021. From a zero remainder, data 0x00000001 gives 0x00001021.
- R3: After a CRC-16 operation, bits [31:16] of both the result and the stored remainder are zero, even when the register held nonzero upper bits before.
- R4: `res_valid` is high exactly in the cycle after each cycle with `op_valid` high, and low otherwise. Back-to-back operations give back-to-back results in issue order.
- R5: The new remainder is written to the register of the context given by `op_ctx`, so the next operation on that context continues from it.
- R6: A load (`ld_valid`) writes `ld_value` into the register of context `ld_ctx`. The new value appears on `rd_value` from the next cycle.
- R7: When an operation and a load address the same context in the same cycle, the load is dropped and the operation's result is stored.
- R8: Contexts are independent. An operation or load on one context leaves every other context's remainder unchanged, and a load and an operation on different contexts in the same cycle both take effect.
- R9: After reset every remainder reads zero and `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_type | input | 1 | 1 = CRC-32, 0 = CRC-16 |
| op_ctx | input | CTX_W | Context whose remainder is used |
| op_data | input | DW | Data word from the datapath |
| ld_valid | input | 1 | Direct load strobe |
| ld_ctx | input | CTX_W | Context to load |
| ld_value | input | 32 | Value to load |
| rd_ctx | input | CTX_W | Context to read |
| rd_value | output | 32 | Remainder of context `rd_ctx` |
| res_valid | output | 1 | Result valid, one cycle after the strobe |
| res_data | output | 32 | New remainder of the operation |

## Verification
The hardest case to reach from the ports is a load and an operation hitting the same context on the same clock edge, because it needs two independent strobes aligned to one cycle. The driver task takes an optional load alongside each operation, so this cycle is scripted directly. The bench then reads the register back to confirm the load was dropped, and repeats the pairing on different contexts to confirm both take effect. A CRC-16 operation on a register loaded with nonzero upper bits forces the clearing of those bits.

// File: rtl/crc_accum.sv
module crc_accum #(
  parameter int CTX_N = 4,
  parameter int DW = 32,
  parameter logic [31:0] POLY32 = 32'h04C11DB7,
  parameter logic [15:0] POLY16 = 16'h1021,
  localparam int CTX_W = (CTX_N > 1) ? $clog2(CTX_N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic             op_type,
  input  logic [CTX_W-1:0] op_ctx,
  input  logic [DW-1:0]    op_data,
  input  logic             ld_valid,
  input  logic [CTX_W-1:0] ld_ctx,
  input  logic [31:0]      ld_value,
  input  logic [CTX_W-1:0] rd_ctx,
  output logic [31:0]      rd_value,
  output logic             res_valid,
  output logic [31:0]      res_data
);

  function automatic logic [31:0] adv32(input logic [31:0] r, input logic [DW-1:0] d);
    logic [31:0] s;
    s = r;
    for (int i = DW - 1; i >= 0; i--)
      s = (s[31] ^ d[i]) ? ((s << 1) ^ POLY32) : (s << 1);
    return s;
  endfunction

  function automatic logic [15:0] adv16(input logic [15:0] r, input logic [DW-1:0] d);
    logic [15:0] s;
    s = r;
    for (int i = DW - 1; i >= 0; i--)
      s = (s[15] ^ d[i]) ? ((s << 1) ^ POLY16) : (s << 1);
    return s;
  endfunction

  logic [31:0] rem [CTX_N];
  logic [31:0] cur, nxt;
  logic        res_is16;

  assign cur      = rem[op_ctx];
  assign nxt      = op_type ? adv32(cur, op_data) : {16'h0, adv16(cur[15:0], op_data)};
  assign rd_value = rem[rd_ctx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < CTX_N; c++) rem[c] <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_is16  <= 1'b0;
    end else begin
      for (int c = 0; c < CTX_N; c++) begin
        if (op_valid && op_ctx == CTX_W'(c))      rem[c] <= nxt;
        else if (ld_valid && ld_ctx == CTX_W'(c)) rem[c] <= ld_value;
      end
      res_valid <= op_valid;
      if (op_valid) begin
        res_data <= nxt;
        res_is16 <= ~op_type;
      end
    end
  end

  logic             chk_ld, chk_op;
  logic [CTX_W-1:0] chk_ld_ctx, chk_op_ctx;
  logic [31:0]      chk_ld_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_ld <= 1'b0; chk_op <= 1'b0;
      chk_ld_ctx <= '0; chk_op_ctx <= '0; chk_ld_val <= '0;
    end else begin
      chk_ld     <= ld_valid && !(op_valid && op_ctx == ld_ctx);
      chk_op     <= op_valid;
      chk_ld_ctx <= ld_ctx;
      chk_op_ctx <= op_ctx;
      chk_ld_val <= ld_value;
    end
  end

  p_res_timing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);
  p_res_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_valid);
  p_crc16_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_is16) |-> (res_data[31:16] == 16'h0));
  p_writeback_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_op |-> (rem[chk_op_ctx] == res_data));
  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_ld |-> (rem[chk_ld_ctx] == chk_ld_val));

endmodule

// File: tb/tb_crc_accum.sv
module tb_crc_accum;
  localparam int CTX_N = 4;
  localparam int CTX_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 0, op_type = 0, ld_valid = 0;
  logic [CTX_W-1:0] op_ctx = '0, ld_ctx = '0, rd_ctx = '0;
  logic [31:0] op_data = '0, ld_value = '0;
  logic [31:0] rd_value, res_data;
  logic res_valid;

  crc_accum #(.CTX_N(CTX_N)) dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_type(op_type),
    .op_ctx(op_ctx), .op_data(op_data), .ld_valid(ld_valid), .ld_ctx(ld_ctx),
    .ld_value(ld_value), .rd_ctx(rd_ctx), .rd_value(rd_value),
    .res_valid(res_valid), .res_data(res_data));

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] model [CTX_N];
  logic [31:0] q_val[$];
  int          q_cyc[$];
  string       q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] ref_crc(input logic [31:0] r, input logic [31:0] d, input logic is32);
    logic [63:0] v;
    logic [47:0] w;
    if (is32) begin
      v = {r ^ d, 32'h0};
      for (int i = 63; i >= 32; i--) if (v[i]) v[i -: 33] = v[i -: 33] ^ {1'b1, 32'h04C11DB7};
      return v[31:0];
    end
    w = {({r[15:0], 16'h0} ^ d), 16'h0};
    for (int i = 47; i >= 16; i--) if (w[i]) w[i -: 17] = w[i -: 17] ^ {1'b1, 16'h1021};
    return {16'h0, w[15:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input int c, input logic t, input logic [31:0] d, input string tag,
                       input logic l = 0, input int lc = 0, input logic [31:0] lv = 0);
    logic [31:0] e;
    op_valid = 1; op_type = t; op_ctx = CTX_W'(c); op_data = d;
    ld_valid = l; ld_ctx = CTX_W'(lc); ld_value = lv;
    e = ref_crc(model[c], d, t);
    model[c] = e;
    if (l && lc != c) model[lc] = lv;
    q_val.push_back(e); q_cyc.push_back(cyc + 1); q_tag.push_back(tag);
    @(posedge clk); #1;
    op_valid = 0; ld_valid = 0;
  endtask

  task automatic load(input int c, input logic [31:0] v);
    ld_valid = 1; ld_ctx = CTX_W'(c); ld_value = v;
    model[c] = v;
    @(posedge clk); #1;
    ld_valid = 0;
  endtask

  task automatic rd(input int c, input string tag);
    @(negedge clk);
    rd_ctx = CTX_W'(c);
    #1 chk(tag, rd_value, model[c]);
  endtask

  always @(negedge clk) if (rst_n && res_valid) begin
    if (q_val.size() == 0) chk("R4 unexpected result", res_data, 32'hx);
    else begin
      automatic logic [31:0] e = q_val.pop_front();
      automatic int ec = q_cyc.pop_front();
      automatic string tg = q_tag.pop_front();
      chk(tg, res_data, e);
      chk("R4 result cycle", 32'(cyc), 32'(ec));
    end
  end

  initial begin
    #(8 * 50000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < CTX_N; c++) model[c] = 32'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    for (int c = 0; c < CTX_N; c++) rd(c, "R9 reset remainder");
    chk("R9 res_valid after reset", {31'h0, res_valid}, 32'h0);
    @(posedge clk); #1;

    drive(0, 1, 32'h1, "R1 crc32 unit word");
    chk("R1 known value", model[0], 32'h04C11DB7);
    drive(1, 0, 32'h1, "R2 crc16 unit word");
    chk("R2 known value", model[1], 32'h00001021);

    load(0, 32'hFFFFFFFF);
    rd(0, "R6 load visible");
    @(posedge clk); #1;
    drive(0, 1, 32'h12345678, "R1 crc32 chain a");
    drive(0, 1, 32'h9ABCDEF0, "R5 crc32 chain b");
    drive(0, 1, 32'hDEADBEEF, "R5 crc32 chain c");
    rd(0, "R5 writeback");

    load(2, 32'hA5A5FFFF);
    @(posedge clk); #1;
    drive(2, 0, 32'hCAFEF00D, "R3 crc16 upper cleared result");
    rd(2, "R3 crc16 upper cleared register");
    drive(2, 0, 32'h00000000, "R2 crc16 zero data");

    drive(3, 1, 32'h0F0F0F0F, "R4 back-to-back 32");
    drive(3, 0, 32'hF0F0F0F0, "R4 back-to-back 16");
    drive(1, 1, 32'h80000000, "R4 back-to-back other ctx");
    rd(3, "R8 ctx3 holds");

    drive(1, 1, 32'h11111111, "R7 op wins", 1, 1, 32'h55555555);
    rd(1, "R7 load dropped");
    drive(2, 1, 32'h22222222, "R8 parallel op", 1, 3, 32'h77777777);
    rd(3, "R8 parallel load");
    rd(2, "R8 parallel op stored");
    rd(0, "R8 untouched ctx");

    repeat (3) @(posedge clk);
    chk("R4 queue drained", 32'(q_val.size()), 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule